// File: doc/BRIEF.md
# Debug Trigger Match and Chaining Unit

This block holds ten hardware debug triggers and checks them every cycle against three pipeline event streams: instruction-fetch program counters, load addresses and store addresses. The triggers are grouped into five fixed pairs. Each pair may be linked so that it fires only when both members match in the same cycle. From the individual matches the block works out which triggers fire. It reports a sticky per-trigger fire vector, a combined hit flag, and whether a trap is wanted before the current instruction or after it.

Software sets up each trigger through a single write port. One write carries a trigger index and the whole configuration record: the comparison mode, the data-select bit, the timing bit, the action bit, the link bit and the compare value. Results are registered one cycle after the event and build up until a synchronous clear.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset all outputs are 0 and every trigger is disarmed. A trigger that has never been written never matches, even when an event carries address 0.
- R2: A write with `cfg_wr_en`=1 and `cfg_wr_idx` in 0..9 replaces that trigger's record and arms the trigger. An index from 10 to 15 changes nothing and arms nothing.
- R3: The event kind of each trigger is fixed by its index. Triggers 0, 1, 6 and 8 watch fetch. Triggers 2, 3 and 7 watch stores. Triggers 4, 5 and 9 watch loads. A trigger can only match in a cycle in which its own event valid is 1.
- R4: The comparison mode `cfg_mtype` works as follows: 0 matches when the address equals the compare value; 2 matches when the address is greater than or equal to it; 3 matches when the address is less than it (unsigned); 1 never matches.
- R5: On a store trigger, select bit 1 compares `store_data` instead of `store_addr`. On fetch and load triggers the select bit has no effect, so load data is never compared.
- R6: Pair i is made of triggers 2i and 2i+1. The link bit written with trigger 2i links the pair. The link bit written with an odd index is ignored. A linked pair fires both members only when both match, and neither member otherwise. An unlinked pair fires each member on its own match.
- R7: In a linked pair whose two members hold different timing bits, neither member fires, even when both match.
- R8: Pair 1 (triggers 2 and 3, both store) can never be linked. Its members always fire independently.
- R9: `fire_vec` bit t becomes 1 on the clock edge that samples the event which fires trigger t. It stays 1 until a cycle with `hit_clear`=1. A clear takes priority over any event in the same cycle.
- R10: `hit_any` is 1 when any bit of `fire_vec` is 1. `hit_before` is 1 when some trigger fired with timing bit 0 (trap at the current instruction). `hit_after` is 1 when some trigger fired with timing bit 1 (trap at the next instruction). All three follow the same sticky and clear rule as `fire_vec`.
- R11: `hit_action` is 1 when some trigger fired with its action bit 1, with the same sticky and clear rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | 4 | Trigger index for the write |
| cfg_mtype | input | 2 | Comparison mode |
| cfg_sel | input | 1 | Data-select bit (store triggers only) |
| cfg_timing | input | 1 | 0 = trap before, 1 = trap after |
| cfg_action | input | 1 | Action bit reported on fire |
| cfg_chain | input | 1 | Link bit (taken from even indices) |
| cfg_value | input | CMP_W | Compare value |
| fetch_valid | input | 1 | Fetch event valid |
| fetch_pc | input | CMP_W | Fetch program counter |
| load_valid | input | 1 | Load event valid |
| load_addr | input | CMP_W | Load address |
| store_valid | input | 1 | Store event valid |
| store_addr | input | CMP_W | Store address |
| store_data | input | CMP_W | Store data |
| hit_clear | input | 1 | Synchronous clear of pending hits |
| fire_vec | output | 10 | Sticky per-trigger fire bits |
| hit_any | output | 1 | Any trigger fired |
| hit_before | output | 1 | A timing-0 trigger fired |
| hit_after | output | 1 | A timing-1 trigger fired |
| hit_action | output | 1 | A fired trigger had action set |

## Verification
The assertions take for granted that the inputs are driven to known values from the first clock edge after reset. A fire bit can only appear after its own event kind was valid, and a cycle with no event and no clear must leave every output unchanged. The stimulus changes inputs only between edges. It holds the event valids low during configuration writes and clear cycles, except in the one case that tests a clear and an event together. This keeps every rise of a fire bit tied to a single event cycle.

// File: rtl/dbg_trig_pkg.sv
// Shared constants and helpers for the debug trigger unit.
// Assumes the fixed ten-trigger, five-pair arrangement.
package dbg_trig_pkg;
    localparam int NUM_PAIRS = 5;
    localparam int NUM_TRIG  = 2 * NUM_PAIRS;
    localparam int IDX_W     = $clog2(NUM_TRIG);

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2
    } ev_kind_e;

    localparam logic [1:0] MT_EQ   = 2'd0;
    localparam logic [1:0] MT_RSVD = 2'd1;
    localparam logic [1:0] MT_GE   = 2'd2;
    localparam logic [1:0] MT_LT   = 2'd3;

    // Event kind watched by trigger t (pairs: F/F, S/S, L/L, F/S, F/L).
    function automatic ev_kind_e kind_of(input int t);
        case (t)
            0, 1, 6, 8: kind_of = KIND_FETCH;
            2, 3, 7:    kind_of = KIND_STORE;
            default:    kind_of = KIND_LOAD;
        endcase
    endfunction
endpackage

// File: rtl/dbg_trig_cfg_bank.sv
// Configuration storage for all triggers.
// Holds per-trigger mode, select, timing, action, compare value and an
// armed flag, plus one link bit per pair taken from the even member.
// Assumes writes with an index outside the trigger range are dropped.
module dbg_trig_cfg_bank
    import dbg_trig_pkg::*;
#(
    parameter int CMP_W = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [1:0]                   wr_mtype,
    input  logic                         wr_sel,
    input  logic                         wr_timing,
    input  logic                         wr_action,
    input  logic                         wr_chain,
    input  logic [CMP_W-1:0]             wr_value,
    output logic [NUM_TRIG-1:0]          armed,
    output logic [NUM_TRIG-1:0][1:0]     mtype,
    output logic [NUM_TRIG-1:0]          sel,
    output logic [NUM_TRIG-1:0]          timing,
    output logic [NUM_TRIG-1:0]          action,
    output logic [NUM_TRIG-1:0][CMP_W-1:0] value,
    output logic [NUM_PAIRS-1:0]         chain
);
    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        // Capture one trigger's record on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed[t]  <= 1'b0;
                mtype[t]  <= MT_RSVD;
                sel[t]    <= 1'b0;
                timing[t] <= 1'b0;
                action[t] <= 1'b0;
                value[t]  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(t)) begin
                armed[t]  <= 1'b1;
                mtype[t]  <= wr_mtype;
                sel[t]    <= wr_sel;
                timing[t] <= wr_timing;
                action[t] <= wr_action;
                value[t]  <= wr_value;
            end
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        // Capture the pair link bit from writes to the even member.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[p] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(2 * p)) begin
                chain[p] <= wr_chain;
            end
        end
    end
endmodule

// File: rtl/dbg_trig_cmp.sv
// Single-trigger comparator.
// Picks address or data as the operand and applies the comparison mode.
// Assumes the caller routes the event stream that matches this trigger's kind.
module dbg_trig_cmp
    import dbg_trig_pkg::*;
#(
    parameter int CMP_W   = 64,
    parameter bit DATA_OK = 1'b0
) (
    input  logic             armed,
    input  logic             ev_valid,
    input  logic [CMP_W-1:0] ev_addr,
    input  logic [CMP_W-1:0] ev_data,
    input  logic             sel,
    input  logic [1:0]       mtype,
    input  logic [CMP_W-1:0] value,
    output logic             match
);
    logic             use_data;
    logic [CMP_W-1:0] operand;
    logic             cmp_ok;

    assign use_data = DATA_OK && sel;
    assign operand  = use_data ? ev_data : ev_addr;

    // Evaluate the selected comparison mode.
    always_comb begin
        case (mtype)
            MT_EQ:   cmp_ok = (operand == value);
            MT_GE:   cmp_ok = (operand >= value);
            MT_LT:   cmp_ok = (operand <  value);
            default: cmp_ok = 1'b0;
        endcase
    end

    assign match = armed && ev_valid && cmp_ok;
endmodule

// File: rtl/dbg_trig_pair.sv
// Pair resolution: applies linking and the timing-agreement rule.
// Assumes LINK_OK is cleared for pairs that may never be linked.
module dbg_trig_pair #(
    parameter bit LINK_OK = 1'b1
) (
    input  logic match_lo,
    input  logic match_hi,
    input  logic chain,
    input  logic timing_lo,
    input  logic timing_hi,
    output logic fire_lo,
    output logic fire_hi
);
    logic linked;
    logic both_ok;

    assign linked  = LINK_OK && chain;
    assign both_ok = match_lo && match_hi && (timing_lo == timing_hi);

    // Pick joint or independent firing.
    always_comb begin
        if (linked) begin
            fire_lo = both_ok;
            fire_hi = both_ok;
        end else begin
            fire_lo = match_lo;
            fire_hi = match_hi;
        end
    end
endmodule

// File: rtl/dbg_trig_unit.sv
// Top of the debug trigger unit.
// Routes events to comparators by fixed trigger kind, resolves pairs and
// keeps sticky hit state until a synchronous clear.
// Assumes event inputs are stable around the clock edge.
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int CMP_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [IDX_W-1:0]    cfg_wr_idx,
    input  logic [1:0]          cfg_mtype,
    input  logic                cfg_sel,
    input  logic                cfg_timing,
    input  logic                cfg_action,
    input  logic                cfg_chain,
    input  logic [CMP_W-1:0]    cfg_value,
    input  logic                fetch_valid,
    input  logic [CMP_W-1:0]    fetch_pc,
    input  logic                load_valid,
    input  logic [CMP_W-1:0]    load_addr,
    input  logic                store_valid,
    input  logic [CMP_W-1:0]    store_addr,
    input  logic [CMP_W-1:0]    store_data,
    input  logic                hit_clear,
    output logic [NUM_TRIG-1:0] fire_vec,
    output logic                hit_any,
    output logic                hit_before,
    output logic                hit_after,
    output logic                hit_action
);
    logic [NUM_TRIG-1:0]            armed, sel, timing, action;
    logic [NUM_TRIG-1:0][1:0]       mtype;
    logic [NUM_TRIG-1:0][CMP_W-1:0] value;
    logic [NUM_PAIRS-1:0]           chain;
    logic [NUM_TRIG-1:0]            match, fire_now;
    logic [NUM_TRIG-1:0]            fire_q;
    logic                           before_q, after_q, action_q;

    dbg_trig_cfg_bank #(.CMP_W(CMP_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_idx    (cfg_wr_idx),
        .wr_mtype  (cfg_mtype),
        .wr_sel    (cfg_sel),
        .wr_timing (cfg_timing),
        .wr_action (cfg_action),
        .wr_chain  (cfg_chain),
        .wr_value  (cfg_value),
        .armed     (armed),
        .mtype     (mtype),
        .sel       (sel),
        .timing    (timing),
        .action    (action),
        .value     (value),
        .chain     (chain)
    );

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_cmp
        localparam ev_kind_e KIND = kind_of(t);
        logic             v_sel;
        logic [CMP_W-1:0] a_sel;
        logic [CMP_W-1:0] d_sel;
        if (KIND == KIND_FETCH) begin : g_f
            assign v_sel = fetch_valid;
            assign a_sel = fetch_pc;
            assign d_sel = fetch_pc;
        end else if (KIND == KIND_LOAD) begin : g_l
            assign v_sel = load_valid;
            assign a_sel = load_addr;
            assign d_sel = load_addr;
        end else begin : g_s
            assign v_sel = store_valid;
            assign a_sel = store_addr;
            assign d_sel = store_data;
        end
        dbg_trig_cmp #(
            .CMP_W   (CMP_W),
            .DATA_OK (KIND == KIND_STORE)
        ) u_cmp (
            .armed    (armed[t]),
            .ev_valid (v_sel),
            .ev_addr  (a_sel),
            .ev_data  (d_sel),
            .sel      (sel[t]),
            .mtype    (mtype[t]),
            .value    (value[t]),
            .match    (match[t])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        dbg_trig_pair #(.LINK_OK(kind_of(2*p) != KIND_STORE || kind_of(2*p+1) != KIND_STORE)) u_pair (
            .match_lo  (match[2*p]),
            .match_hi  (match[2*p+1]),
            .chain     (chain[p]),
            .timing_lo (timing[2*p]),
            .timing_hi (timing[2*p+1]),
            .fire_lo   (fire_now[2*p]),
            .fire_hi   (fire_now[2*p+1])
        );
    end

    // Accumulate fire state and trap flags; clear wins over new fires.
    always_ff @(posedge clk) begin
        if (!rst_n || hit_clear) begin
            fire_q   <= '0;
            before_q <= 1'b0;
            after_q  <= 1'b0;
            action_q <= 1'b0;
        end else begin
            fire_q   <= fire_q | fire_now;
            before_q <= before_q | (|(fire_now & ~timing));
            after_q  <= after_q  | (|(fire_now & timing));
            action_q <= action_q | (|(fire_now & action));
        end
    end

    assign fire_vec   = fire_q;
    assign hit_any    = |fire_q;
    assign hit_before = before_q;
    assign hit_after  = after_q;
    assign hit_action = action_q;
endmodule

// File: rtl/dbg_trig_unit_chk.sv
// Assertion checker for dbg_trig_unit, bound to every instance.
// Assumes inputs are known from the first edge after reset.
module dbg_trig_unit_chk
    import dbg_trig_pkg::*;
#(
    parameter int CMP_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fetch_valid,
    input logic                load_valid,
    input logic                store_valid,
    input logic                hit_clear,
    input logic [NUM_TRIG-1:0] fire_vec,
    input logic                hit_any,
    input logic                hit_before,
    input logic                hit_after
);
    logic any_ev;
    assign any_ev = fetch_valid || load_valid || store_valid;

    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clear |=> (fire_vec == '0));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_clear |=> ((fire_vec & $past(fire_vec)) == $past(fire_vec)));

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ev && !hit_clear) |=> $stable(fire_vec));

    a_r10_any_has_timing: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> (hit_before || hit_after));

    a_r3_load_kind: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fire_vec[4]) || $rose(fire_vec[5]) || $rose(fire_vec[9])) |-> $past(load_valid));

    a_r3_store_kind: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fire_vec[2]) || $rose(fire_vec[3]) || $rose(fire_vec[7])) |-> $past(store_valid));
endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(.CMP_W(CMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .load_valid  (load_valid),
    .store_valid (store_valid),
    .hit_clear   (hit_clear),
    .fire_vec    (fire_vec),
    .hit_any     (hit_any),
    .hit_before  (hit_before),
    .hit_after   (hit_after)
);

// File: tb/dbg_trig_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_trig_unit_tb_top;
    localparam int W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [3:0] cfg_wr_idx = '0;
    logic [1:0] cfg_mtype = '0;
    logic cfg_sel = 1'b0, cfg_timing = 1'b0, cfg_action = 1'b0, cfg_chain = 1'b0;
    logic [W-1:0] cfg_value = '0;
    logic fetch_valid = 1'b0, load_valid = 1'b0, store_valid = 1'b0;
    logic [W-1:0] fetch_pc = '0, load_addr = '0, store_addr = '0, store_data = '0;
    logic hit_clear = 1'b0;
    logic [9:0] fire_vec;
    logic hit_any, hit_before, hit_after, hit_action;

    int n_checks = 0;
    int n_errors = 0;

    // Bench mirror of configuration, built from the requirements.
    bit         m_armed [10];
    bit [1:0]   m_mt    [10];
    bit         m_sel   [10];
    bit         m_tim   [10];
    bit         m_act   [10];
    bit [W-1:0] m_val   [10];
    bit         m_ch    [5];

    always #2.5 clk = ~clk;

    dbg_trig_unit #(.CMP_W(W)) dut_i (.*);

    function automatic int kind(int t); // 0 fetch, 1 load, 2 store (R3)
        if (t == 0 || t == 1 || t == 6 || t == 8) return 0;
        if (t == 2 || t == 3 || t == 7) return 2;
        return 1;
    endfunction

    function automatic bit cmpf(bit [1:0] mt, bit [W-1:0] a, bit [W-1:0] v); // R4
        case (mt)
            2'd0: return a == v;
            2'd2: return a >= v;
            2'd3: return a < v;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit [9:0] model(bit fv, bit [W-1:0] fa, bit lv, bit [W-1:0] la,
                                       bit sv, bit [W-1:0] sa, bit [W-1:0] sd);
        bit [9:0] m, f;
        for (int t = 0; t < 10; t++) begin
            bit v; bit [W-1:0] a;
            case (kind(t))
                0: begin v = fv; a = fa; end
                1: begin v = lv; a = la; end
                default: begin v = sv; a = m_sel[t] ? sd : sa; end // R5
            endcase
            m[t] = m_armed[t] && v && cmpf(m_mt[t], a, m_val[t]);
        end
        for (int p = 0; p < 5; p++) begin
            if (m_ch[p] && p != 1) begin // R6, R8
                bit both;
                both = m[2*p] && m[2*p+1] && (m_tim[2*p] == m_tim[2*p+1]); // R7
                f[2*p] = both; f[2*p+1] = both;
            end else begin
                f[2*p] = m[2*p]; f[2*p+1] = m[2*p+1];
            end
        end
        return f;
    endfunction

    task automatic check_outs(bit [9:0] ef, string req);
        bit eb, ea, ec;
        eb = 0; ea = 0; ec = 0;
        for (int t = 0; t < 10; t++) begin
            if (ef[t] && !m_tim[t]) eb = 1;
            if (ef[t] &&  m_tim[t]) ea = 1;
            if (ef[t] &&  m_act[t]) ec = 1;
        end
        n_checks++;
        if (fire_vec !== ef) begin
            n_errors++;
            $display("FAIL %s fire_vec actual=%b expected=%b", req, fire_vec, ef);
        end
        n_checks++;
        if ({hit_any, hit_before, hit_after, hit_action} !== {|ef, eb, ea, ec}) begin
            n_errors++;
            $display("FAIL %s R10/R11 flags actual=%b expected=%b", req,
                     {hit_any, hit_before, hit_after, hit_action}, {|ef, eb, ea, ec});
        end
    endtask

    task automatic cfg(int idx, bit [1:0] mt, bit s, bit tm, bit ac, bit ch, bit [W-1:0] v);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_idx = 4'(idx); cfg_mtype = mt; cfg_sel = s;
        cfg_timing = tm; cfg_action = ac; cfg_chain = ch; cfg_value = v;
        @(negedge clk);
        cfg_wr_en = 0;
        if (idx < 10) begin // R2
            m_armed[idx] = 1; m_mt[idx] = mt; m_sel[idx] = s;
            m_tim[idx] = tm; m_act[idx] = ac; m_val[idx] = v;
            if (idx % 2 == 0) m_ch[idx/2] = ch;
        end
    endtask

    task automatic drive_ev(bit fv, bit [W-1:0] fa, bit lv, bit [W-1:0] la,
                            bit sv, bit [W-1:0] sa, bit [W-1:0] sd, bit clr);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = fa; load_valid = lv; load_addr = la;
        store_valid = sv; store_addr = sa; store_data = sd; hit_clear = clr;
        @(negedge clk);
        fetch_valid = 0; load_valid = 0; store_valid = 0; hit_clear = 0;
    endtask

    task automatic one_shot(bit fv, bit [W-1:0] fa, bit lv, bit [W-1:0] la,
                            bit sv, bit [W-1:0] sa, bit [W-1:0] sd, string req);
        drive_ev(0, 0, 0, 0, 0, 0, 0, 1);
        drive_ev(fv, fa, lv, la, sv, sa, sd, 0);
        check_outs(model(fv, fa, lv, la, sv, sa, sd), req);
    endtask

    initial begin
        #(5.0 * 190000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        bit [9:0] acc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_outs('0, "R1 reset state");
        one_shot(1, 0, 1, 0, 1, 0, 0, "R1 unwritten triggers at address 0");

        // R3 R4 R5: each trigger alone, every mode, operand below/equal/above, select on/off.
        for (int t = 0; t < 10; t++) begin
            for (int mt = 0; mt < 4; mt++) begin
                for (int s = 0; s < 2; s++) begin
                    cfg(t, 2'(mt), 1'(s), 1'(t % 2), 1'(mt % 2), 0, 100);
                    for (int k = 0; k < 3; k++) begin
                        for (int off = 99; off <= 101; off++) begin
                            one_shot(k == 0, W'(off), k == 1, W'(off), k == 2, W'(off), W'(200 - off),
                                     "R3/R4/R5 single trigger sweep");
                        end
                    end
                end
            end
            cfg(t, 2'd1, 0, 0, 0, 0, 100);
        end

        // R6 R7 R8: every pair, link on/off, timing and match combinations.
        for (int p = 0; p < 5; p++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int tt = 0; tt < 4; tt++) begin
                    for (int mm = 0; mm < 4; mm++) begin
                        cfg(2*p+1, 0, 0, 1'(tt >> 1), 1, 1, mm[1] ? 10 : 999); // odd link bit ignored
                        cfg(2*p, 0, 0, 1'(tt & 1), 0, 1'(ch), mm[0] ? 10 : 999);
                        one_shot(1, 10, 1, 10, 1, 10, 10, "R6/R7/R8 pair link sweep");
                    end
                end
            end
            cfg(2*p, 1, 0, 0, 0, 0, 0);
            cfg(2*p+1, 1, 0, 0, 0, 0, 0);
        end

        // R2: out-of-range indices write nothing.
        for (int idx = 10; idx < 16; idx++) cfg(idx, 0, 0, 0, 1, 0, 10);
        one_shot(1, 10, 1, 10, 1, 10, 10, "R2 out-of-range index ignored");

        // R9 R10: sticky accumulation and clear priority.
        cfg(0, 0, 0, 0, 0, 0, 10);
        cfg(6, 0, 0, 1, 1, 0, 20);
        drive_ev(0, 0, 0, 0, 0, 0, 0, 1);
        drive_ev(1, 10, 0, 0, 0, 0, 0, 0);
        acc = 10'b0000000001;
        check_outs(acc, "R9 first fire registered");
        drive_ev(1, 20, 0, 0, 0, 0, 0, 0);
        acc = 10'b0001000001;
        check_outs(acc, "R9/R10 sticky accumulate before+after");
        drive_ev(0, 0, 0, 0, 0, 0, 0, 0);
        check_outs(acc, "R9 held with no event");
        drive_ev(1, 10, 0, 0, 0, 0, 0, 1);
        check_outs('0, "R9 clear wins over event");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule